// File: doc/BRIEF.md
# Multi-Page-Size Fully Associative Translation Buffer

This block translates 32-bit virtual addresses into 32-bit physical addresses through a small table that is searched in full on every lookup. Each entry holds a virtual tag, a physical base, a two-bit mapping-size code and a valid bit. The size code sets the mapping span, which is one of 4 KB, 64 KB, 1 MB or 16 MB. It therefore also sets how many high virtual address bits must match and how many low offset bits pass through unchanged.

Software fills the table through a write port that addresses one entry at a time. It can drop a single entry by index, or empty the whole table with a flush. A lookup is presented for one clock and answered one clock later with a hit or a fault. A miss is only reported: the block latches the faulting address in a sticky record and raises a level interrupt. That interrupt stays high until software acknowledges it. The entry count is the parameter `ENTRIES`, with 8 and 32 as the intended builds.

Top module: `tlb_xlate`

## Requirements
- R1: After reset `rsp_valid`, `rsp_hit`, `rsp_fault` and `irq` are 0, `fault_va` is 0 and every entry is invalid.
- R2: Each cycle with `lk_req` high produces exactly one response, with `rsp_valid` high on the following cycle. In that response exactly one of `rsp_hit` and `rsp_fault` is 1, and `rsp_pa` is 0 on a fault. With no request the next cycle has `rsp_valid`, `rsp_hit` and `rsp_fault` all 0.
- R3: Size code 2'b00 maps 4 KB and compares VA[31:12]. Code 2'b01 maps 64 KB and compares VA[31:16]. Code 2'b10 maps 1 MB and compares VA[31:20]. Code 2'b11 maps 16 MB and compares VA[31:24]. Tag bits below the compared range are ignored.
- R4: On a hit `rsp_pa` takes the entry base bits above the offset boundary and the lookup address bits below it. Base bits below the boundary are ignored.
- R5: When several valid entries match, the entry with the lowest index supplies the translation.
- R6: A write with `wr_en` loads tag (`wr_vtag` = VA[31:12]), base (`wr_pbase` = PA[31:12]), size and valid into entry `wr_idx`. It replaces the old contents, and a write with `wr_valid` = 0 leaves the entry unable to match.
- R7: `inv_en` clears the valid bit of entry `inv_idx` only; the other entries keep translating.
- R8: `flush` clears every valid bit. It overrides a write or invalidate in the same cycle.
- R9: A lookup that matches no valid entry sets `irq` and records its address in `fault_va` if `irq` was clear. Later misses while `irq` is set leave `fault_va` unchanged.
- R10: `fault_clr` clears `irq` on the next edge. A miss in the same cycle as `fault_clr` wins: `irq` stays 1 and `fault_va` takes the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load one entry |
| wr_idx | input | IDXW | Entry index to load |
| wr_vtag | input | 20 | Virtual tag, VA[31:12] |
| wr_pbase | input | 20 | Physical base, PA[31:12] |
| wr_size | input | 2 | Mapping-size code |
| wr_valid | input | 1 | Valid bit written with the entry |
| inv_en | input | 1 | Invalidate one entry |
| inv_idx | input | IDXW | Entry index to invalidate |
| flush | input | 1 | Invalidate all entries |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| rsp_valid | output | 1 | Response strobe, one clock after request |
| rsp_hit | output | 1 | Translation found |
| rsp_fault | output | 1 | No valid entry matched |
| rsp_pa | output | 32 | Translated physical address |
| irq | output | 1 | Sticky fault interrupt |
| fault_va | output | 32 | First faulting address since last clear |
| fault_clr | input | 1 | Acknowledge and clear the fault |

## Verification
A lookup answer is due on the clock edge after the request. `irq` and `fault_va` change on that same edge, and table writes, invalidates and flushes affect lookups issued from the following cycle on. The bench drives all inputs on the falling edge and queues one expected response per request. A monitor pops the queue at every falling edge where `rsp_valid` is high, which is half a clock after the registered answer appears. Fault-record checks are made one falling edge after the missing request or the acknowledge, and the queue must be empty at the end.

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int ENTRIES = 8,
  localparam int IDXW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [19:0]     wr_vtag,
  input  logic [19:0]     wr_pbase,
  input  logic [1:0]      wr_size,
  input  logic            wr_valid,
  input  logic            inv_en,
  input  logic [IDXW-1:0] inv_idx,
  input  logic            flush,
  input  logic            lk_req,
  input  logic [31:0]     lk_va,
  output logic            rsp_valid,
  output logic            rsp_hit,
  output logic            rsp_fault,
  output logic [31:0]     rsp_pa,
  output logic            irq,
  output logic [31:0]     fault_va,
  input  logic            fault_clr
);

  logic [19:0] tag_q  [ENTRIES];
  logic [19:0] base_q [ENTRIES];
  logic [1:0]  size_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;

  logic [ENTRIES-1:0] match;
  logic [19:0] keep_mask [ENTRIES];

  function automatic logic [19:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'b00:   size_mask = 20'hFFFFF;
      2'b01:   size_mask = 20'hFFFF0;
      2'b10:   size_mask = 20'hFFF00;
      default: size_mask = 20'hFF000;
    endcase
  endfunction

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign keep_mask[g] = size_mask(size_q[g]);
    assign match[g] = vld_q[g] &&
                      (((lk_va[31:12] ^ tag_q[g]) & keep_mask[g]) == 20'h0);
  end

  logic        hit;
  logic [31:0] pa_sel;

  always_comb begin
    pa_sel = 32'h0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i])
        pa_sel = ({base_q[i], 12'h0} & {keep_mask[i], 12'h0}) |
                 (lk_va & ~{keep_mask[i], 12'h0});
    end
  end

  assign hit = |match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i]  <= '0;
        base_q[i] <= '0;
        size_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (flush) begin
          vld_q[i] <= 1'b0;
        end else begin
          if (inv_en && inv_idx == IDXW'(i))
            vld_q[i] <= 1'b0;
          if (wr_en && wr_idx == IDXW'(i)) begin
            tag_q[i]  <= wr_vtag;
            base_q[i] <= wr_pbase;
            size_q[i] <= wr_size;
            vld_q[i]  <= wr_valid;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_pa    <= '0;
      irq       <= 1'b0;
      fault_va  <= '0;
    end else begin
      rsp_valid <= lk_req;
      rsp_hit   <= lk_req && hit;
      rsp_fault <= lk_req && !hit;
      rsp_pa    <= (lk_req && hit) ? pa_sel : 32'h0;
      if (lk_req && !hit) begin
        irq <= 1'b1;
        if (!irq || fault_clr)
          fault_va <= lk_va;
      end else if (fault_clr) begin
        irq <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        lk_req,
  input logic        rsp_valid,
  input logic        rsp_hit,
  input logic        rsp_fault,
  input logic        irq,
  input logic        fault_clr,
  input logic [31:0] fault_va
);

  AST_RESP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> rsp_valid); // R2
  AST_NO_RESP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> (!rsp_valid && !rsp_hit && !rsp_fault)); // R2
  AST_HIT_XOR_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit ^ rsp_fault)); // R2
  AST_FAULT_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> irq); // R9
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !fault_clr) |=> irq); // R9
  AST_FAULT_VA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !fault_clr) |=> $stable(fault_va)); // R9
  AST_CLR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_clr && !lk_req) |=> !irq); // R10

endmodule

bind tlb_xlate tlb_xlate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .irq(irq),
  .fault_clr(fault_clr), .fault_va(fault_va)
);

// File: tb/sim_tlb_xlate.sv
module sim_tlb_xlate;
  localparam int N = 8;
  localparam int IW = $clog2(N);

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_valid = 0, inv_en = 0, flush = 0, lk_req = 0, fault_clr = 0;
  logic [IW-1:0] wr_idx = '0, inv_idx = '0;
  logic [19:0] wr_vtag = '0, wr_pbase = '0;
  logic [1:0]  wr_size = '0;
  logic [31:0] lk_va = '0;
  logic rsp_valid, rsp_hit, rsp_fault, irq;
  logic [31:0] rsp_pa, fault_va;

  always #10 clk = ~clk;

  tlb_xlate #(.ENTRIES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_vtag(wr_vtag),
    .wr_pbase(wr_pbase), .wr_size(wr_size), .wr_valid(wr_valid), .inv_en(inv_en),
    .inv_idx(inv_idx), .flush(flush), .lk_req(lk_req), .lk_va(lk_va),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa),
    .irq(irq), .fault_va(fault_va), .fault_clr(fault_clr));

  int tests = 0, fails = 0;
  bit done = 0;
  logic [32:0] q_exp[$];
  string       q_tag[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q_exp.size() == 0) begin
        chk("R2 unexpected response", 32'h1, 32'h0);
      end else begin
        logic [32:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        chk({t, " hit"}, {31'h0, rsp_hit}, {31'h0, e[32]});
        chk({t, " fault"}, {31'h0, rsp_fault}, {31'h0, ~e[32]});
        chk({t, " pa"}, rsp_pa, e[31:0]);
      end
    end
  end

  task automatic clr_ctl();
    wr_en = 0; inv_en = 0; flush = 0; lk_req = 0; fault_clr = 0;
  endtask

  task automatic idle();
    @(negedge clk); clr_ctl();
  endtask

  task automatic wr(input int idx, input logic [19:0] vt, input logic [19:0] pb,
                    input logic [1:0] sz, input logic v);
    @(negedge clk); clr_ctl();
    wr_en = 1; wr_idx = IW'(idx); wr_vtag = vt; wr_pbase = pb; wr_size = sz; wr_valid = v;
  endtask

  task automatic lkp(input logic [31:0] va, input logic h, input logic [31:0] pa,
                     input string tag, input logic clr = 0);
    @(negedge clk); clr_ctl();
    lk_req = 1; lk_va = va; fault_clr = clr;
    q_exp.push_back({h, h ? pa : 32'h0});
    q_tag.push_back(tag);
  endtask

  initial begin
    #(20 * 100000);
    chk("watchdog", 32'h1, 32'h0);
    done = 1;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 fault_va", fault_va, 32'h0);
    lkp(32'h1234_5ABC, 0, 0, "R1 empty table miss");
    idle(); @(negedge clk);
    @(negedge clk); fault_clr = 1; idle();

    wr(0, 20'h12345, 20'h87654, 2'b00, 1);
    wr(1, 20'h20007, 20'h9ABCD, 2'b01, 1);
    wr(2, 20'h30012, 20'h45678, 2'b10, 1);
    wr(3, 20'h40ABC, 20'hC3DEF, 2'b11, 1);
    lkp(32'h1234_5ABC, 1, 32'h8765_4ABC, "R3 R4 4K");
    lkp(32'h2000_F123, 1, 32'h9ABC_F123, "R3 R4 64K");
    lkp(32'h300A_BCDE, 1, 32'h456A_BCDE, "R3 R4 1M");
    lkp(32'h40FE_DCBA, 1, 32'hC3FE_DCBA, "R3 R4 16M");
    lkp(32'h2001_0000, 0, 0, "R3 64K bound miss");
    idle();
    chk("R9 irq set", {31'h0, irq}, 32'h1);
    chk("R9 fault_va", fault_va, 32'h2001_0000);
    lkp(32'h1234_6000, 0, 0, "R3 4K bound miss");
    idle();
    chk("R9 fault_va held", fault_va, 32'h2001_0000);
    @(negedge clk); fault_clr = 1; idle();
    chk("R10 irq cleared", {31'h0, irq}, 32'h0);

    lkp(32'h5555_5555, 0, 0, "R9 miss");
    lkp(32'h6666_6000, 0, 0, "R10 miss with clear", 1);
    idle();
    chk("R10 miss beats clear irq", {31'h0, irq}, 32'h1);
    chk("R10 miss beats clear va", fault_va, 32'h6666_6000);
    @(negedge clk); fault_clr = 1; idle();

    wr(5, 20'h12000, 20'hAA000, 2'b11, 1);
    wr(4, 20'h12345, 20'h11111, 2'b00, 1);
    lkp(32'h1234_5ABC, 1, 32'h8765_4ABC, "R5 lowest index");
    lkp(32'h12FF_0000, 1, 32'hAAFF_0000, "R5 single 16M");
    @(negedge clk); clr_ctl(); inv_en = 1; inv_idx = 0;
    lkp(32'h1234_5ABC, 1, 32'h1111_1ABC, "R7 R5 after invalidate");
    lkp(32'h2000_0004, 1, 32'h9ABC_0004, "R7 others kept");
    wr(6, 20'h77777, 20'h12121, 2'b00, 0);
    lkp(32'h7777_7000, 0, 0, "R6 written invalid");
    wr(1, 20'h20000, 20'hBEEF0, 2'b00, 1);
    lkp(32'h2000_0444, 1, 32'hBEEF_0444, "R6 overwrite");
    lkp(32'h2000_1444, 0, 0, "R6 overwrite size");
    idle();
    @(negedge clk); fault_clr = 1; idle();

    @(negedge clk); clr_ctl(); flush = 1;
    wr_en = 1; wr_idx = 7; wr_vtag = 20'h60000; wr_pbase = 20'h1; wr_size = 0; wr_valid = 1;
    lkp(32'h40FE_DCBA, 0, 0, "R8 flushed");
    lkp(32'h6000_0000, 0, 0, "R8 flush beats write");
    lkp(32'h1234_5ABC, 0, 0, "R8 flushed 4K");
    idle(); idle();
    chk("R2 queue drained", q_exp.size(), 0);
    done = 1;
  end

  initial begin
    wait (done);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule